// File: doc/BRIEF.md
# Gated Event Timer with Selectable, Edge-Aligned Gate

This block is a 16-bit up-counter that advances once per period of a prescaled timing clock. Counting can be qualified by a gate taken from one of two places. The first is a digital gate input from outside the chip. The second is a comparator decision that arrives as a digital level. Software uses it to measure how long an analog or external condition stays true, or the spacing between such events.

The whole block runs on one system clock. The raw timing clock reaches it as a one-cycle strobe, `tick_i`. A prescaler divides that strobe by 1, 2, 4 or 8. It produces two events in each prescaled period:

- a **rise** event, on which the counter may advance;
- a **fall** event, half a period earlier, on which the comparator level can be captured.

When the comparator gate is resampled this way, it never changes on the same event that counts. A one-byte configuration register holds two bits:

- one selects between the outside pin and the comparator;
- one turns resampling on or off.

Top module: `gated_timer`

## Requirements
- R1: After reset `count_o` is 0, `ovf_o` is 0 and `reg_rdata_o` reads 0x02 (outside gate selected, resampling off).
- R2: A register write stores `reg_wdata_i[1]` as gate source (1 = outside pin, 0 = comparator) and `reg_wdata_i[0]` as resample enable. Bits 7..2 always read 0, so writing 0xFF reads back 0x03.
- R3: While `tmr_on_i` is 0 the count does not change, whatever the ticks and gates do.
- R4: With `tmr_on_i` = 1 and `gate_en_i` = 0, the count rises by exactly one on every prescaled rise event. The count never changes by any other amount.
- R5: `pre_sel_i` values 0, 1, 2 and 3 give 1, 2, 4 and 8 ticks per rise event. With no tick, the count holds.
- R6: Any change of `pre_sel_i` clears the prescaler phase in that cycle, and that cycle produces no rise event.
- R7: With gate control on and source = outside pin, `ext_gate_i` passes through two flops before use. The count advances only while that delayed level is 1, and the comparator is ignored.
- R8: With source = comparator and resampling off, the level of `cmp_i` in the rise cycle itself decides the count. The outside pin is ignored.
- R9: With source = comparator and resampling on, `cmp_i` is captured on each fall event. Fall events occur at prescaler phase ratio/2-1, or on every tick for ratio 1. A rise event uses the value captured at an earlier fall, never the level present during the rise.
- R10: The count wraps from 0xFFFF to 0x0000. `ovf_o` is 1 for exactly the one cycle in which the count reads 0x0000 after that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per period of the raw timing clock |
| pre_sel_i | input | 2 | Prescaler ratio select (ratio = 2^value) |
| tmr_on_i | input | 1 | Timer run enable |
| gate_en_i | input | 1 | Gate control enable |
| ext_gate_i | input | 1 | Outside gate level, asynchronous |
| cmp_i | input | 1 | Comparator decision level |
| reg_we_i | input | 1 | Configuration register write strobe |
| reg_wdata_i | input | 8 | Configuration write data |
| reg_rdata_o | output | 8 | Configuration read data |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
A wrong prescaler phase shows up as a count that lands one step early or late after a fixed run of ticks. The bench can see this within at most eight ticks of the disturbance, because the division by 2, 4 and 8 is checked right after each ratio change. A stale or mis-timed comparator latch makes the resampled and direct modes give the same increment for the pattern 1,0,0,0. The two modes should differ by one within four ticks, so such a fault appears there. A synchronizer of the wrong depth shifts the first gated increment by one tick. A broken wrap shows at the single cycle that follows the 65536th increment.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int CNT_W    = 16;
    localparam int SEL_W    = 2;
    localparam int REG_W    = 8;
    localparam int PCW      = (1 << SEL_W) - 1;
    localparam int SRC_BIT  = 1;
    localparam int SYNC_BIT = 0;
    localparam int SYNC_STG = 2;

    typedef struct packed {
        logic src_ext;
        logic sync_en;
    } gt_cfg_t;

    localparam gt_cfg_t CFG_RST = '{src_ext: 1'b1, sync_en: 1'b0};

    typedef struct packed {
        logic rise;
        logic fall;
    } pre_evt_t;

    function automatic logic [PCW-1:0] last_phase(input logic [SEL_W-1:0] sel);
        return PCW'((32'd1 << sel) - 32'd1);
    endfunction

    function automatic logic [PCW-1:0] mid_phase(input logic [SEL_W-1:0] sel);
        if (sel == '0)
            return '0;
        return PCW'((32'd1 << (sel - 1'b1)) - 32'd1);
    endfunction
endpackage

// File: rtl/gtmr_cfg_reg.sv
module gtmr_cfg_reg
    import gtmr_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output gt_cfg_t       cfg,
    output logic [DW-1:0] rdata
);
    logic unused_hi;
    assign unused_hi = ^wdata[DW-1:2];

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RST;
        else if (we)
            cfg <= '{src_ext: wdata[SRC_BIT], sync_en: wdata[SYNC_BIT]};
    end

    always_comb begin
        rdata           = '0;
        rdata[SRC_BIT]  = cfg.src_ext;
        rdata[SYNC_BIT] = cfg.sync_en;
    end
endmodule

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler
    import gtmr_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [SW-1:0] sel,
    output pre_evt_t      evt
);
    localparam int CW = (1 << SW) - 1;

    logic [CW-1:0] phase;
    logic [SW-1:0] sel_q;
    logic          clr;

    assign clr = (sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel;
            if (clr)
                phase <= '0;
            else if (tick)
                phase <= (phase == last_phase(sel)) ? '0 : phase + 1'b1;
        end
    end

    always_comb begin
        evt.rise = tick && !clr && (phase == last_phase(sel));
        evt.fall = tick && !clr && (phase == mid_phase(sel));
    end
endmodule

// File: rtl/gtmr_gate_sel.sv
module gtmr_gate_sel
    import gtmr_pkg::*;
#(
    parameter int STAGES = SYNC_STG
) (
    input  logic    clk,
    input  logic    rst,
    input  gt_cfg_t cfg,
    input  logic    ext_gate,
    input  logic    cmp,
    input  logic    fall,
    output logic    gate
);
    logic [STAGES-1:0] ext_sh;
    logic              cmp_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ext_sh[gi] <= 1'b0;
                    else     ext_sh[gi] <= ext_gate;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) ext_sh[gi] <= 1'b0;
                    else     ext_sh[gi] <= ext_sh[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= 1'b0;
        else if (fall)
            cmp_q <= cmp;
    end

    always_comb begin
        if (cfg.src_ext)
            gate = ext_sh[STAGES-1];
        else if (cfg.sync_en)
            gate = cmp_q;
        else
            gate = cmp;
    end
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter
    import gtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise,
    input  logic         run,
    input  logic         gate_en,
    input  logic         gate,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic inc;
    assign inc = rise && run && (!gate_en || gate);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc && (&count);
            if (inc)
                count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
    import gtmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [SW-1:0] pre_sel_i,
    input  logic          tmr_on_i,
    input  logic          gate_en_i,
    input  logic          ext_gate_i,
    input  logic          cmp_i,
    input  logic          reg_we_i,
    input  logic [RW-1:0] reg_wdata_i,
    output logic [RW-1:0] reg_rdata_o,
    output logic [CW-1:0] count_o,
    output logic          ovf_o
);
    gt_cfg_t  cfg;
    pre_evt_t evt;
    logic     gate;

    gtmr_cfg_reg #(.DW(RW)) u_cfg (
        .clk(clk), .rst(rst), .we(reg_we_i), .wdata(reg_wdata_i),
        .cfg(cfg), .rdata(reg_rdata_o)
    );

    gtmr_prescaler #(.SW(SW)) u_pre (
        .clk(clk), .rst(rst), .tick(tick_i), .sel(pre_sel_i), .evt(evt)
    );

    gtmr_gate_sel #(.STAGES(SYNC_STG)) u_gate (
        .clk(clk), .rst(rst), .cfg(cfg), .ext_gate(ext_gate_i),
        .cmp(cmp_i), .fall(evt.fall), .gate(gate)
    );

    gtmr_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .rise(evt.rise), .run(tmr_on_i),
        .gate_en(gate_en_i), .gate(gate), .count(count_o), .ovf(ovf_o)
    );
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
    parameter int CW = 16,
    parameter int SW = 2,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_i,
    input logic [SW-1:0] pre_sel_i,
    input logic          tmr_on_i,
    input logic [RW-1:0] reg_rdata_o,
    input logic [CW-1:0] count_o,
    input logic          ovf_o
);
    // R10
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (count_o == '0));

    // R10
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o);

    // R3
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_on_i |=> $stable(count_o));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (count_o != $past(count_o)) |-> (count_o == CW'($past(count_o) + 1'b1)));

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));

    // R6
    resel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_sel_i != $past(pre_sel_i)) |=> $stable(count_o));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata_o[RW-1:2] == '0);
endmodule

bind gated_timer gtmr_chk #(.CW(CW), .SW(SW), .RW(RW)) u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .pre_sel_i(pre_sel_i),
    .tmr_on_i(tmr_on_i), .reg_rdata_o(reg_rdata_o),
    .count_o(count_o), .ovf_o(ovf_o)
);

// File: tb/sim_gated_timer.sv
`timescale 1ns/1ps
module sim_gated_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [1:0]  pre_sel_i = 2'd0;
    logic        tmr_on_i = 1'b0;
    logic        gate_en_i = 1'b0;
    logic        ext_gate_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  reg_rdata_o;
    logic [15:0] count_o;
    logic        ovf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gated_timer u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .pre_sel_i(pre_sel_i),
        .tmr_on_i(tmr_on_i), .gate_en_i(gate_en_i), .ext_gate_i(ext_gate_i),
        .cmp_i(cmp_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .count_o(count_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we_i = 1'b1;
        reg_wdata_i = v;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic set_sel(input logic [1:0] v);
        pre_sel_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(count_o), 32'h0);
        chk("R1 ovf", 32'(ovf_o), 32'h0);
        chk("R1 cfg", 32'(reg_rdata_o), 32'h02);
    endtask

    task automatic t_reg();
        wr(8'hFF);
        chk("R2 ff", 32'(reg_rdata_o), 32'h03);
        wr(8'h00);
        chk("R2 00", 32'(reg_rdata_o), 32'h00);
        wr(8'hFE);
        chk("R2 fe", 32'(reg_rdata_o), 32'h02);
    endtask

    task automatic t_off();
        logic [15:0] b;
        b = count_o;
        tmr_on_i = 1'b0;
        gate_en_i = 1'b0;
        ticks(5);
        chk("R3 off", 32'(count_o), 32'(b));
        tmr_on_i = 1'b1;
    endtask

    task automatic t_free();
        logic [15:0] b;
        b = count_o;
        ticks(7);
        chk("R4 free", 32'(count_o), 32'(b + 16'd7));
        idle(3);
        chk("R5 no tick", 32'(count_o), 32'(b + 16'd7));
    endtask

    task automatic t_ratio();
        logic [15:0] b;
        for (int s = 1; s < 4; s++) begin
            set_sel(2'(s));
            b = count_o;
            ticks(16);
            chk("R5 ratio", 32'(count_o), 32'(b + 16'(16 >> s)));
        end
    endtask

    task automatic t_clear();
        logic [15:0] b;
        set_sel(2'd2);
        ticks(3);
        set_sel(2'd3);
        b = count_o;
        ticks(7);
        chk("R6 cleared", 32'(count_o), 32'(b));
        ticks(1);
        chk("R6 eighth", 32'(count_o), 32'(b + 16'd1));
    endtask

    task automatic t_ext();
        logic [15:0] b;
        set_sel(2'd0);
        wr(8'h02);
        gate_en_i = 1'b1;
        ext_gate_i = 1'b0;
        cmp_i = 1'b1;
        idle(3);
        b = count_o;
        ticks(5);
        chk("R7 low", 32'(count_o), 32'(b));
        ext_gate_i = 1'b1;
        ticks(3);
        chk("R7 sync delay", 32'(count_o), 32'(b + 16'd1));
        ticks(4);
        chk("R7 high", 32'(count_o), 32'(b + 16'd5));
    endtask

    task automatic t_cmp_direct();
        logic [15:0] b;
        wr(8'h00);
        ext_gate_i = 1'b1;
        cmp_i = 1'b0;
        b = count_o;
        ticks(4);
        chk("R8 cmp low", 32'(count_o), 32'(b));
        cmp_i = 1'b1;
        ticks(4);
        chk("R8 cmp high", 32'(count_o), 32'(b + 16'd4));
        ext_gate_i = 1'b0;
    endtask

    task automatic t_cmp_sync();
        logic [15:0] b;
        wr(8'h01);
        set_sel(2'd1);
        b = count_o;
        cmp_i = 1'b1; ticks(1);
        cmp_i = 1'b0; ticks(1);
        ticks(2);
        chk("R9 latched", 32'(count_o), 32'(b + 16'd1));
        wr(8'h00);
        set_sel(2'd0);
        set_sel(2'd1);
        b = count_o;
        cmp_i = 1'b1; ticks(1);
        cmp_i = 1'b0; ticks(1);
        ticks(2);
        chk("R8 direct same pattern", 32'(count_o), 32'(b));
        wr(8'h01);
        set_sel(2'd0);
        b = count_o;
        cmp_i = 1'b1;
        ticks(1);
        chk("R9 ratio1 old", 32'(count_o), 32'(b));
        ticks(1);
        chk("R9 ratio1 new", 32'(count_o), 32'(b + 16'd1));
    endtask

    task automatic t_wrap();
        wr(8'h02);
        gate_en_i = 1'b0;
        ticks(65535 - int'(count_o));
        chk("R10 top", 32'(count_o), 32'hFFFF);
        chk("R10 no ovf yet", 32'(ovf_o), 32'h0);
        ticks(1);
        chk("R10 wrap", 32'(count_o), 32'h0);
        chk("R10 ovf", 32'(ovf_o), 32'h1);
        idle(1);
        chk("R10 ovf one cycle", 32'(ovf_o), 32'h0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_reg();
        t_off();
        t_free();
        t_ratio();
        t_clear();
        t_ext();
        t_cmp_direct();
        t_cmp_sync();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule